// File: doc/BRIEF.md
# Three-Share Masked 4-bit S-box with Run-Time Affine Layers

This block evaluates a 4-bit nonlinear substitution on data held in three Boolean shares, so that no single internal wire carries the unmasked value. The substitution is built as five layers in a chain. An input affine map comes first. A fixed quadratic permutation follows, then a middle affine map, then the same quadratic permutation again, and last an output affine map. Each quadratic layer is built from three component functions. Each component reads only two of the three shares, which keeps every output share blind to one input share.

The three affine maps are not wired in. Each one is given at the ports as a 4x4 binary matrix and a 4-bit constant, and is applied to every share on its own. A cipher datapath can therefore load a fresh, randomly chosen equivalent decomposition before each encryption without spending a configuration cycle. A register holding all three shares sits after the middle affine. It keeps glitches from the first quadratic layer out of the second. A second register holds the result. An accepted input appears at the output two cycles later, and a new input can be accepted on every cycle. The affine configuration must not change while an operation is still inside the two stages.

Top module: `tiSboxTop`

## Requirements
- R1: While rstN is low, and after its release, outValid is 0 and outShares is 0 until the first accepted input comes out.
- R2: An affine is configured by a 16-bit matrix and a 4-bit constant. Bit r of the result is the XOR of (matrix bits [4r+3:4r] AND the 4-bit input), XORed with constant bit r. Share k occupies bits [4k+3:4k] of inShares and of outShares. The XOR of the three output shares equals Aout(Q(Amid(Q(Ain(x))))), where x is the XOR of the three input shares.
- R3: Q maps input bits (a,b,c,d), with a at bit 0, to e=a, f=b^bd^cd, g=c^bd, h=d. The bench checks this with identity matrices (16'h8421) and zero constants, where the recombined result must equal Q(Q(x)).
- R4: Input accepted while inValid is high at a rising edge is presented with outValid high exactly two rising edges later. Back-to-back inputs on consecutive cycles all come out in order.
- R5: When inValid is low, no register is updated: outShares keeps its last value and outValid goes low, whatever inShares carries.
- R6: A matrix of all zeros ignores its input. With all three matrices zero, the recombined output equals the output constant for every input and mask.
- R7: With invertible matrices, the 12-bit map from the three input shares to the three output shares is a bijection. This is the uniformity of the sharing.
- R8: After an accepted input has come out, outShares holds no unknown bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input shares are valid this cycle |
| inShares | input | 12 | Three 4-bit input shares, share k at [4k+3:4k] |
| cfgInMat | input | 16 | Input affine matrix, row r at [4r+3:4r] |
| cfgInConst | input | 4 | Input affine constant |
| cfgMidMat | input | 16 | Middle affine matrix |
| cfgMidConst | input | 4 | Middle affine constant |
| cfgOutMat | input | 16 | Output affine matrix |
| cfgOutConst | input | 4 | Output affine constant |
| outValid | output | 1 | Output shares carry a fresh result |
| outShares | output | 12 | Three 4-bit output shares |

## Verification
The bench builds the block with its default parameters: 4-bit shares and three shares. With those values the whole shared input space of 4096 combinations is small enough to stream through in one run. That makes the bijection check of R7 exhaustive under a random invertible configuration, rather than a sample. Every unmasked input value is also covered under several random affine configurations, each with fresh random masks. This is mixed with directed identity and zero-matrix configurations that isolate the quadratic map and the constant path.

// File: rtl/tiSboxPkg.sv
package tiSboxPkg;
  localparam int SHARE_W   = 4;
  localparam int SHARE_CNT = 3;
  localparam int MAT_W     = SHARE_W * SHARE_W;
  localparam int BUS_W     = SHARE_W * SHARE_CNT;

  typedef struct packed {
    logic [MAT_W-1:0]   mat;
    logic [SHARE_W-1:0] cst;
  } affineCfg_t;

  typedef struct packed {
    logic loadMid;
    logic loadOut;
  } stageStrobe_t;

  // Component function of the quadratic map; reads share i and share j only.
  function automatic logic [3:0] quadComponent(input logic [3:0] si, input logic [3:0] sj);
    logic ai, bi, ci, di, bj, cj, dj;
    logic [3:0] r;
    ai = si[0]; bi = si[1]; ci = si[2]; di = si[3];
    bj = sj[1]; cj = sj[2]; dj = sj[3];
    r[0] = ai;
    r[1] = bi ^ (bj & dj) ^ (cj & dj) ^ (dj & bi) ^ (dj & ci) ^ (bj & di) ^ (cj & di);
    r[2] = ci ^ (bj & dj) ^ (dj & bi) ^ (bj & di);
    r[3] = di;
    return r;
  endfunction
endpackage

// File: rtl/tiAffineLayer.sv
module tiAffineLayer
  import tiSboxPkg::*;
#(
  parameter int W   = SHARE_W,
  parameter int CNT = SHARE_CNT
) (
  input  logic [W*W-1:0] mat,
  input  logic [W-1:0]   cst,
  input  logic [W*CNT-1:0] din,
  output logic [W*CNT-1:0] dout
);
  for (genvar s = 0; s < CNT; s++) begin : gShare
    for (genvar r = 0; r < W; r++) begin : gRow
      assign dout[s*W + r] = (^(mat[r*W +: W] & din[s*W +: W])) ^ cst[r];
    end
  end
endmodule

// File: rtl/tiQuadLayer.sv
module tiQuadLayer
  import tiSboxPkg::*;
(
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout
);
  // Output share k uses shares (k+1) and (k+2) modulo the share count.
  for (genvar k = 0; k < SHARE_CNT; k++) begin : gComp
    localparam int I = (k + 1) % SHARE_CNT;
    localparam int J = (k + 2) % SHARE_CNT;
    assign dout[k*SHARE_W +: SHARE_W] =
      quadComponent(din[I*SHARE_W +: SHARE_W], din[J*SHARE_W +: SHARE_W]);
  end
endmodule

// File: rtl/tiSboxDatapath.sv
module tiSboxDatapath
  import tiSboxPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  stageStrobe_t strobe,
  input  logic [BUS_W-1:0] inShares,
  input  affineCfg_t   cfgIn,
  input  affineCfg_t   cfgMid,
  input  affineCfg_t   cfgOut,
  output logic [BUS_W-1:0] outShares
);
  logic [BUS_W-1:0] afterIn, afterQ1, afterMid, midReg, afterQ2, afterOut, outReg;

  tiAffineLayer uAffIn (.mat(cfgIn.mat), .cst(cfgIn.cst), .din(inShares), .dout(afterIn));
  tiQuadLayer   uQuad1 (.din(afterIn), .dout(afterQ1));
  tiAffineLayer uAffMid (.mat(cfgMid.mat), .cst(cfgMid.cst), .din(afterQ1), .dout(afterMid));

  always_ff @(posedge clk) begin
    if (!rstN)              midReg <= '0;
    else if (strobe.loadMid) midReg <= afterMid;
  end

  tiQuadLayer   uQuad2 (.din(midReg), .dout(afterQ2));
  tiAffineLayer uAffOut (.mat(cfgOut.mat), .cst(cfgOut.cst), .din(afterQ2), .dout(afterOut));

  always_ff @(posedge clk) begin
    if (!rstN)               outReg <= '0;
    else if (strobe.loadOut) outReg <= afterOut;
  end

  assign outShares = outReg;
endmodule

// File: rtl/tiSboxControl.sv
module tiSboxControl
  import tiSboxPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic midValid, doneValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      midValid  <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      midValid  <= inValid;
      doneValid <= midValid;
    end
  end

  always_comb begin
    strobe.loadMid = inValid;
    strobe.loadOut = midValid;
  end

  assign outValid = doneValid;
endmodule

// File: rtl/tiSboxTop.sv
module tiSboxTop
  import tiSboxPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [11:0] inShares,
  input  logic [15:0] cfgInMat,
  input  logic [3:0]  cfgInConst,
  input  logic [15:0] cfgMidMat,
  input  logic [3:0]  cfgMidConst,
  input  logic [15:0] cfgOutMat,
  input  logic [3:0]  cfgOutConst,
  output logic        outValid,
  output logic [11:0] outShares
);
  stageStrobe_t strobe;
  affineCfg_t   cfgIn, cfgMid, cfgOut;

  assign cfgIn  = '{mat: cfgInMat,  cst: cfgInConst};
  assign cfgMid = '{mat: cfgMidMat, cst: cfgMidConst};
  assign cfgOut = '{mat: cfgOutMat, cst: cfgOutConst};

  tiSboxControl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe), .outValid(outValid)
  );

  tiSboxDatapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inShares(inShares),
    .cfgIn(cfgIn), .cfgMid(cfgMid), .cfgOut(cfgOut), .outShares(outShares)
  );
endmodule

// File: rtl/tiSboxChecker.sv
module tiSboxChecker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        outValid,
  input logic [11:0] outShares
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> (!outValid && outShares == 12'h0));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rstN) inValid |=> ##1 outValid);

  // R5
  no_input_chk: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> ##1 !outValid);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN) !outValid |-> $stable(outShares));

  // R8
  known_chk: assert property (@(posedge clk) disable iff (!rstN) outValid |-> !$isunknown(outShares));
endmodule

bind tiSboxTop tiSboxChecker chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid), .outShares(outShares)
);

// File: tb/tb_tiSboxTop.sv
module tb_tiSboxTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] inShares = '0;
  logic [15:0] cfgInMat = '0, cfgMidMat = '0, cfgOutMat = '0;
  logic [3:0]  cfgInConst = '0, cfgMidConst = '0, cfgOutConst = '0;
  logic        outValid;
  logic [11:0] outShares;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [11:0] inBuf [4096];
  bit seen [4096];

  always #10 clk = ~clk;

  tiSboxTop dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inShares(inShares),
    .cfgInMat(cfgInMat), .cfgInConst(cfgInConst),
    .cfgMidMat(cfgMidMat), .cfgMidConst(cfgMidConst),
    .cfgOutMat(cfgOutMat), .cfgOutConst(cfgOutConst),
    .outValid(outValid), .outShares(outShares)
  );

  function automatic logic [3:0] affRef(logic [15:0] m, logic [3:0] c, logic [3:0] x);
    logic [3:0] y;
    for (int r = 0; r < 4; r++) begin
      y[r] = c[r];
      for (int k = 0; k < 4; k++) y[r] = y[r] ^ (m[4*r+k] & x[k]);
    end
    return y;
  endfunction

  function automatic logic [3:0] qRef(logic [3:0] x);
    logic a, b, c, d;
    {d, c, b, a} = x;
    return {d, c ^ (b & d), b ^ (b & d) ^ (c & d), a};
  endfunction

  function automatic logic [3:0] fold(logic [11:0] s);
    return s[3:0] ^ s[7:4] ^ s[11:8];
  endfunction

  function automatic logic [3:0] expected(logic [3:0] x);
    return affRef(cfgOutMat, cfgOutConst,
             qRef(affRef(cfgMidMat, cfgMidConst, qRef(affRef(cfgInMat, cfgInConst, x)))));
  endfunction

  function automatic bit invertible(logic [15:0] m);
    logic [15:0] hit = '0;
    for (int x = 0; x < 16; x++) hit[affRef(m, 4'h0, x[3:0])] = 1'b1;
    return hit == 16'hFFFF;
  endfunction

  function automatic logic [15:0] randInvMat();
    logic [15:0] m;
    do m = 16'($urandom); while (!invertible(m));
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] maskShares(logic [3:0] x);
    logic [3:0] m0, m1;
    m0 = 4'($urandom);
    m1 = 4'($urandom);
    return {x ^ m0 ^ m1, m1, m0};
  endfunction

  // Streams n inputs back to back; each result is sampled two edges after driving.
  task automatic stream(input int n, input string req, input bit bij);
    for (int i = 0; i < 4096; i++) seen[i] = 0;
    for (int step = 0; step < n + 2; step++) begin
      @(negedge clk);
      if (step >= 2) begin
        if (bij) seen[outShares] = 1;
        else check(outValid && fold(outShares) == expected(fold(inBuf[step-2])), req,
                   {outValid, 7'h0, fold(outShares)}, {8'h80, expected(fold(inBuf[step-2]))});
      end
      if (step < n) begin inValid = 1; inShares = inBuf[step]; end
      else inValid = 0;
    end
  endtask

  task automatic allValues(input string req);
    for (int i = 0; i < 16; i++) inBuf[i] = maskShares(i[3:0]);
    stream(16, req, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(!outValid && outShares == 0, "R1 during reset", {outValid, outShares[10:0]}, 12'h0);
    rstN = 1;
    @(negedge clk);
    check(!outValid && outShares == 0, "R1 after release", {outValid, outShares[10:0]}, 12'h0);

    // R3: identity matrices isolate the quadratic map
    cfgInMat = 16'h8421; cfgMidMat = 16'h8421; cfgOutMat = 16'h8421;
    allValues("R3 identity affines");

    // R6: zero matrices leave only the output constant
    cfgInMat = 0; cfgMidMat = 0; cfgOutMat = 0;
    cfgInConst = 4'h9; cfgMidConst = 4'h6; cfgOutConst = 4'hB;
    for (int i = 0; i < 16; i++) inBuf[i] = maskShares(i[3:0]);
    for (int step = 0; step < 18; step++) begin
      @(negedge clk);
      if (step >= 2) check(fold(outShares) == 4'hB, "R6 zero matrix", {8'h0, fold(outShares)}, 12'h00B);
      inValid = step < 16; inShares = inBuf[step % 16];
    end
    inValid = 0;

    // R4: single operation latency
    cfgInMat = randInvMat(); cfgMidMat = randInvMat(); cfgOutMat = randInvMat();
    cfgInConst = 4'($urandom); cfgMidConst = 4'($urandom); cfgOutConst = 4'($urandom);
    @(negedge clk); inValid = 1; inShares = maskShares(4'h7);
    @(negedge clk); inValid = 0; inShares = 12'hFFF;
    check(!outValid, "R4 not yet valid after one edge", {11'h0, outValid}, 12'h0);
    @(negedge clk);
    check(outValid && fold(outShares) == expected(4'h7), "R4 valid after two edges",
          {outValid, 7'h0, fold(outShares)}, {8'h80, expected(4'h7)});

    // R5: outputs hold while inValid is low, whatever inShares carries
    begin
      logic [11:0] held;
      held = outShares;
      inShares = 12'h5A3;
      repeat (3) @(negedge clk);
      check(!outValid && outShares == held, "R5 hold without valid", outShares, held);
    end

    // R2: random configurations, masks and all unmasked values, back to back
    for (int c = 0; c < 8; c++) begin
      cfgInMat = 16'($urandom); cfgMidMat = 16'($urandom); cfgOutMat = 16'($urandom);
      cfgInConst = 4'($urandom); cfgMidConst = 4'($urandom); cfgOutConst = 4'($urandom);
      allValues("R2 random affines");
    end

    // R7: exhaustive bijection over the 12-bit shared space
    cfgInMat = randInvMat(); cfgMidMat = randInvMat(); cfgOutMat = randInvMat();
    cfgInConst = 4'($urandom); cfgMidConst = 4'($urandom); cfgOutConst = 4'($urandom);
    for (int i = 0; i < 4096; i++) inBuf[i] = i[11:0];
    stream(4096, "R7", 1);
    begin
      int hits = 0;
      for (int i = 0; i < 4096; i++) hits += seen[i];
      check(hits == 4096, "R7 shared bijection", 12'(hits), 12'(4096));
    end

    // R8: outputs known after results
    check(!$isunknown(outShares), "R8 known outputs", outShares, outShares);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule